// File: doc/BRIEF.md
# External interrupt sense unit

This block conditions four external interrupt request pins before they reach the interrupt priority logic. Each pin is first brought into the clock domain. It is then interpreted by a 2-bit sense code, which selects active-high level, rising edge, falling edge or active-low level. The result is gated by a per-line enable. In the two edge modes a detected edge is held in a sticky pending bit until software acknowledges it.

Line 0 feeds the critical group and lines 1 to 3 feed the main group. Even so, all four lines are set up through one shared control word on a simple write/read bus. That word holds the sense codes (bits 2i+1:2i), the enables (bits 8+i, 1 = enabled) and write-only acknowledge bits (bits 12+i). The outputs are one qualified request per line for the downstream group logic.

Top module: `xirq_sense`

## Requirements
- R1: While reset is held and after it is released, every line is disabled, every sense code is 0, every pending bit is clear, all requests are 0 and the read-back word is 0.
- R2: A write stores the word. The read-back value is the sense codes in bits 2i+1:2i, the enables in bits 8+i and zero in the acknowledge field bits 15:12. The read-back value changes only after a write.
- R3: Code 0 (active-high level): an enabled line's request equals the pin as seen after two synchronizer flops. A pin change shows on the request two clock edges after it is sampled.
- R4: Code 3 (active-low level): an enabled line's request is the inverse of the synchronized pin, with the same latency as R3.
- R5: Code 1 (rising edge): a 0-to-1 change of the synchronized pin sets the pending bit. The request rises three edges after the pin is sampled high and stays high after the pin falls.
- R6: Code 2 (falling edge): a 1-to-0 change of the synchronized pin sets the pending bit, and the request behaves as in R5.
- R7: Writing 1 to acknowledge bit 12+i clears the pending bit of line i, and the request drops one edge after the write.
- R8: When an edge and an acknowledge hit the same line on the same clock edge, the edge wins and the line stays pending.
- R9: In the level modes an acknowledge has no effect on the request.
- R10: A disabled line never asserts its request. Edges still latch while the line is disabled and show on the request once it is enabled.
- R11: No pending state is kept in the level modes. A pending edge is discarded when its line is switched to a level mode, and it does not return when the line is switched back to an edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_i | input | 4 | Raw external request pins, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 16 | Control word written: codes, enables, acknowledges |
| cfg_rdata_o | output | 16 | Control word read back: codes and enables |
| req_o | output | 4 | Qualified request per line; bit 0 critical, bits 3:1 main |

## Verification
The bench builds the block with its defaults: four lines and two synchronizer stages. With four lines, each of the four sense codes runs on its own line at the same time. With two stages, the latency is two edges for level requests and three edges for latched edges. These latencies are short enough that an acknowledge can be placed on exactly the edge where an edge is detected. A behavioural model keeps the pin history in a queue and is compared with both outputs on every clock.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  // level modes carry no latched state
  function automatic logic sense_is_level(sense_e c);
    return (c == SENSE_LVL_HI) || (c == SENSE_LVL_LO);
  endfunction

  // value of a level-mode request for a synchronized pin value
  function automatic logic level_active(sense_e c, logic s);
    return s ^ (c == SENSE_LVL_LO);
  endfunction

  // edge match from current and previous synchronized samples
  function automatic logic edge_match(sense_e c, logic cur, logic prv);
    case (c)
      SENSE_RISE: return cur & ~prv;
      SENSE_FALL: return ~cur & prv;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg #(
  parameter int NUM_LINES = 4,
  localparam int MASK_LSB = 2 * NUM_LINES,
  localparam int ACK_LSB  = MASK_LSB + NUM_LINES,
  localparam int REG_W    = ACK_LSB + NUM_LINES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [NUM_LINES-1:0][1:0]  code_o,
  output logic [NUM_LINES-1:0]       unmask_o,
  output logic [NUM_LINES-1:0]       ack_o,
  output logic [REG_W-1:0]           rdata_o
);
  logic [NUM_LINES-1:0][1:0] code_q;
  logic [NUM_LINES-1:0]      unmask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      unmask_q <= '0;
    end else if (we_i) begin
      code_q   <= wdata_i[MASK_LSB-1:0];
      unmask_q <= wdata_i[ACK_LSB-1:MASK_LSB];
    end
  end

  // acknowledge bits act only in the write cycle, nothing is stored
  assign ack_o    = we_i ? wdata_i[REG_W-1:ACK_LSB] : '0;
  assign code_o   = code_q;
  assign unmask_o = unmask_q;
  assign rdata_o  = {{NUM_LINES{1'b0}}, unmask_q, code_q};
endmodule

// File: rtl/xirq_line.sv
module xirq_line
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic [1:0] code_i,
  input  logic       unmask_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic       pend_o,
  output logic       edge_o,
  output logic       level_o
);
  sense_e code;
  logic   prev_q;
  logic   pend_q;

  assign code    = sense_e'(code_i);
  assign level_o = sense_is_level(code);
  assign edge_o  = edge_match(code, sync_i, prev_q);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  // priority: level mode discards, edge sets, acknowledge clears
  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (level_o) pend_q <= 1'b0;
    else if (edge_o)  pend_q <= 1'b1;
    else if (ack_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign req_o  = unmask_i & (level_o ? level_active(code, sync_i) : pend_q);
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = 4 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_pin_i,
  input  logic                 cfg_we_i,
  input  logic [REG_W-1:0]     cfg_wdata_i,
  output logic [REG_W-1:0]     cfg_rdata_o,
  output logic [NUM_LINES-1:0] req_o
);
  logic [NUM_LINES-1:0]      sync_w;
  logic [NUM_LINES-1:0][1:0] code_w;
  logic [NUM_LINES-1:0]      unmask_w;
  logic [NUM_LINES-1:0]      ack_w;
  logic [NUM_LINES-1:0]      pend_w;
  logic [NUM_LINES-1:0]      edge_hit_w;
  logic [NUM_LINES-1:0]      level_w;

  xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst (rst), .d_i (irq_pin_i), .q_o (sync_w)
  );

  xirq_cfg #(.NUM_LINES(NUM_LINES)) i_cfg (
    .clk      (clk),
    .rst      (rst),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .code_o   (code_w),
    .unmask_o (unmask_w),
    .ack_o    (ack_w),
    .rdata_o  (cfg_rdata_o)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_line i_line (
      .clk      (clk),
      .rst      (rst),
      .sync_i   (sync_w[i]),
      .code_i   (code_w[i]),
      .unmask_i (unmask_w[i]),
      .ack_i    (ack_w[i]),
      .req_o    (req_o[i]),
      .pend_o   (pend_w[i]),
      .edge_o   (edge_hit_w[i]),
      .level_o  (level_w[i])
    );
  end
endmodule

// File: rtl/xirq_sense_chk.sv
module xirq_sense_chk #(
  parameter int NUM_LINES = 4,
  localparam int REG_W    = 4 * NUM_LINES,
  localparam int ACK_LSB  = 3 * NUM_LINES
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [REG_W-1:0]     cfg_rdata,
  input logic [NUM_LINES-1:0] req,
  input logic [NUM_LINES-1:0] unmask,
  input logic [NUM_LINES-1:0] ack,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] level
);
  // R10: disabled lines stay quiet
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (req & ~unmask) == '0);

  // R2: acknowledge field never reads back, word moves only on a write
  a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[REG_W-1:ACK_LSB] == '0);
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));

  // R8: an edge always leaves its line pending
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)));

  // R7: acknowledge without a competing edge clears
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((ack & ~level & ~edge_hit) != '0) |=> ((pend & $past(ack & ~level & ~edge_hit)) == '0));

  // R11: level mode drops pending state
  a_r11_level_drops: assert property (@(posedge clk) disable iff (rst)
    (level != '0) |=> ((pend & $past(level)) == '0));

  // R5: a pending bit only rises after a detected edge
  a_r5_pend_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(edge_hit)) == '0);
endmodule

bind xirq_sense xirq_sense_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we_i),
  .cfg_rdata (cfg_rdata_o),
  .req       (req_o),
  .unmask    (unmask_w),
  .ack       (ack_w),
  .pend      (pend_w),
  .edge_hit  (edge_hit_w),
  .level     (level_w)
);

// File: tb/test_xirq_sense.sv
module test_xirq_sense;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int W     = 4 * N;
  localparam logic [15:0] BASE = 16'h0FE4; // line0 hi, 1 rise, 2 fall, 3 lo, all enabled

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [N-1:0] req;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  xirq_sense i_xirq_sense (
    .clk (clk), .rst (rst), .irq_pin_i (pin), .cfg_we_i (we),
    .cfg_wdata_i (wdata), .cfg_rdata_o (rdata), .req_o (req)
  );

  task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference
  int         m_code [N];
  bit         m_en   [N];
  bit         m_pend [N];
  logic [N-1:0] hist [$] = '{4'b0, 4'b0, 4'b0}; // [0]=1st flop,[1]=synced,[2]=previous

  always @(posedge clk) begin
    logic [15:0] exp_req, exp_rd;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_code[i] = 0; m_en[i] = 0; m_pend[i] = 0; end
      hist = '{4'b0, 4'b0, 4'b0};
    end else begin
      for (int i = 0; i < N; i++) begin
        bit cur, prv, hit;
        cur = hist[1][i];
        prv = hist[2][i];
        hit = (m_code[i] == 1 && cur && !prv) || (m_code[i] == 2 && !cur && prv);
        if (m_code[i] == 0 || m_code[i] == 3) m_pend[i] = 0;
        else if (hit)                         m_pend[i] = 1;
        else if (we && wdata[3*N+i])          m_pend[i] = 0;
      end
      if (we)
        for (int i = 0; i < N; i++) begin
          m_code[i] = int'(wdata[2*i +: 2]);
          m_en[i]   = wdata[2*N+i];
        end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
    #2;
    exp_req = '0;
    exp_rd  = '0;
    for (int i = 0; i < N; i++) begin
      bit lvl;
      lvl = hist[1][i] ^ (m_code[i] == 3);
      if (m_en[i]) exp_req[i] = (m_code[i] == 0 || m_code[i] == 3) ? lvl : m_pend[i];
      exp_rd[2*i +: 2] = 2'(m_code[i]);
      exp_rd[2*N+i]    = m_en[i];
    end
    check(tag, 16'(req), exp_req);
    check("R2", rdata, exp_rd);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    check("R1 reset req", 16'(req), 16'h0);
    check("R1 reset readback", rdata, 16'h0);
    rst = 1'b0;
    idle(3);
    check("R1 after reset", 16'(req), 16'h0);

    tag = "R2"; wr(BASE | 16'hF000); idle(2);
    check("R2 readback", rdata, BASE);

    tag = "R3"; @(negedge clk) pin[0] = 1'b1; idle(4); pin[0] = 1'b0; idle(4);
    tag = "R4"; @(negedge clk) pin[3] = 1'b1; idle(4); pin[3] = 1'b0; idle(4);

    tag = "R5"; @(negedge clk) pin[1] = 1'b1; idle(5);
    check("R5 rise pending", 16'(req[1]), 16'h1);
    pin[1] = 1'b0; idle(3);
    check("R5 sticky", 16'(req[1]), 16'h1);

    tag = "R7"; wr(BASE | 16'h2000); idle(1);
    check("R7 ack cleared", 16'(req[1]), 16'h0);

    tag = "R6"; @(negedge clk) pin[2] = 1'b1; idle(4); pin[2] = 1'b0; idle(4);
    check("R6 fall pending", 16'(req[2]), 16'h1);
    wr(BASE | 16'h4000); idle(2);

    tag = "R8"; @(negedge clk) pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; wdata = BASE | 16'h2000;
    @(negedge clk); we = 1'b0; wdata = '0;
    idle(2);
    check("R8 edge beats ack", 16'(req[1]), 16'h1);
    pin[1] = 1'b0; wr(BASE | 16'h2000); idle(2);

    tag = "R9"; @(negedge clk) pin[0] = 1'b1; idle(3);
    wr(BASE | 16'h9000); idle(2);
    check("R9 level ignores ack", 16'(req), 16'h9);
    pin[0] = 1'b0; idle(3);

    tag = "R10"; wr(16'h0DE4);
    @(negedge clk) pin[1] = 1'b1; idle(5);
    check("R10 masked quiet", 16'(req[1]), 16'h0);
    wr(BASE); idle(1);
    check("R10 latched while masked", 16'(req[1]), 16'h1);
    pin[1] = 1'b0; wr(BASE | 16'h2000); idle(2);

    tag = "R11"; @(negedge clk) pin[2] = 1'b1; idle(3); pin[2] = 1'b0; idle(4);
    wr(16'h0FC4); idle(2);
    wr(BASE); idle(2);
    check("R11 pending discarded", 16'(req[2]), 16'h0);
    idle(3);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule